// File: doc/BRIEF.md
# Dual-Clock Single-Bit Elastic FIFO

This block buffers a serial bit stream between two clock domains. The producer side runs on `wr_clk` and the consumer side runs on `rd_clk`. The two clocks run freely. They may be unrelated, or they may be the same net. Storage holds `DEPTH` bits, with 64 or 256 as the intended sizes. One extra bit sits in a registered output stage, and that stage is the read port. Each side tracks its own pointer in Gray code. Each pointer reaches the other domain through a chain of flip-flops.

Both data edges use a valid/ready handshake. On the write side, `wr_en` acts as valid and `wr_ready` acts as ready. A bit is taken only on a rising `wr_clk` edge where both are high. While `wr_ready` is low the producer must hold its bit, because any attempt is dropped. On the read side, `rd_valid` acts as valid and `rd_en` acts as ready. While `rd_en` is low the presented bit waits on `rd_data` without change. A rising `rd_clk` edge with both high consumes it, and the next stored bit, if any, takes its place on the same edge.

Occupancy is measured in the write domain. It counts only the bits in storage, never the bit sitting in the output stage. Two status flags come from this count. `half_full` marks the upper half. `almost_edge` warns when the buffer is close to either end. `rd_oe` models a three-state output: `rd_data_en` says whether the pin is driven.

Top module: `serial_fifo_dc`

## Requirements
- R1: A bit on `wr_data` is stored at a rising `wr_clk` edge only when `wr_en` and `wr_ready` are both high; at any other edge the storage and its contents are left unchanged.
- R2: At a rising `rd_clk` edge with `rd_valid` and `rd_en` both high, the presented bit is consumed. While `rd_valid` is high and `rd_en` is low, `rd_data` and `rd_valid` hold.
- R3: `wr_ready` is low exactly when storage holds `DEPTH` bits, so at most `DEPTH`+1 bits are in the block, counting the output stage; no write is ever lost or overwritten.
- R4: Bits leave on `rd_data` in the order in which they were accepted, under any mix of handshake stalls on either side.
- R5: `half_full` is high when the stored count is at least `DEPTH`/2.
- R6: `almost_edge` is high when the stored count is at most `ALMOST` (8) or at least `DEPTH`-`ALMOST`.
- R7: The bit held in the output stage is excluded from the stored count used by `wr_ready`, `half_full` and `almost_edge`.
- R8: With both clocks on one net, a bit written into an empty block at edge E makes `rd_valid` rise after edge E+3 and not before, through three read-clock flip-flop stages.
- R9: With both clocks on one net, a read that frees a location in a full store at edge P raises `wr_ready` after edge P+2 and not before, through two write-clock flip-flop stages.
- R10: While `rst_n` is low, and right after it is released, `wr_ready` is high, `rd_valid` is low, `half_full` is low and `almost_edge` is high.
- R11: With `rd_oe` low, `rd_data_en` is low and `rd_data` reads 0. With `rd_oe` high, `rd_data_en` is high and `rd_data` carries the presented bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset of both sides |
| wr_data | input | 1 | Serial bit to store |
| wr_en | input | 1 | Write request (valid) |
| wr_ready | output | 1 | Room available in storage (ready) |
| rd_en | input | 1 | Consumer accepts the presented bit (ready) |
| rd_valid | output | 1 | A bit is presented on the output (valid) |
| rd_oe | input | 1 | Output drive enable |
| rd_data | output | 1 | Presented bit, 0 when not driven |
| rd_data_en | output | 1 | High when `rd_data` is actively driven |
| half_full | output | 1 | Stored count at least half the depth |
| almost_edge | output | 1 | Stored count within `ALMOST` of empty or full |

## Verification
The hardest state to reach is a completely full block in which a single read must release exactly one write slot, and do so a fixed number of edges later. The stimulus gets there by filling the block one bit at a time. After each bit it lets the pointers settle and checks all three write-side flags against the count the bench computes, which sweeps every occupancy from 0 to `DEPTH`. With both clocks on one net it then pops a single bit and watches `wr_ready` edge by edge. A long mixed run then stalls the producer and the consumer in different periodic patterns, keeping occupancy wandering while the order of bits is compared against a queue.

// File: rtl/serial_fifo_pkg.sv
package serial_fifo_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/serial_fifo_sync.sv
module serial_fifo_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serial_fifo_wr_side.sv
module serial_fifo_wr_side
  import serial_fifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ALMOST = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_sync,
  output logic          wr_ready,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] level,
  output logic          half_full,
  output logic          almost_edge
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);
  localparam logic [PW-1:0] LOW_LVL  = PW'(ALMOST);
  localparam logic [PW-1:0] HIGH_LVL = PW'(DEPTH - ALMOST);

  logic [PW-1:0] wptr, wptr_nxt, rptr_seen;

  assign rptr_seen = PW'(gray2bin(32'(rgray_sync)));
  assign level     = wptr - rptr_seen;
  assign wr_ready  = (level != FULL_LVL);
  assign push      = wr_en && wr_ready;
  assign wptr_nxt  = wptr + PW'(1);
  assign waddr     = wptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (push) begin
      wptr  <= wptr_nxt;
      wgray <= PW'(bin2gray(32'(wptr_nxt)));
    end
  end

  assign half_full   = (level >= HALF_LVL);
  assign almost_edge = (level <= LOW_LVL) || (level >= HIGH_LVL);
endmodule

// File: rtl/serial_fifo_rd_side.sv
module serial_fifo_rd_side
  import serial_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_sync,
  input  logic          mem_bit,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          out_bit,
  output logic          rd_valid
);
  logic [PW-1:0] rptr, rptr_nxt;
  logic          avail, pop, load;

  assign avail    = (rgray != wgray_sync);
  assign pop      = rd_valid && rd_en;
  assign load     = avail && (!rd_valid || pop);
  assign rptr_nxt = rptr + PW'(1);
  assign raddr    = rptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      rgray    <= '0;
      out_bit  <= 1'b0;
      rd_valid <= 1'b0;
    end else if (load) begin
      rptr     <= rptr_nxt;
      rgray    <= PW'(bin2gray(32'(rptr_nxt)));
      out_bit  <= mem_bit;
      rd_valid <= 1'b1;
    end else if (pop) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_fifo_dc.sv
module serial_fifo_dc #(
  parameter int DEPTH  = 64,
  parameter int ALMOST = 8
) (
  input  logic wr_clk,
  input  logic rd_clk,
  input  logic rst_n,
  input  logic wr_data,
  input  logic wr_en,
  output logic wr_ready,
  input  logic rd_en,
  output logic rd_valid,
  input  logic rd_oe,
  output logic rd_data,
  output logic rd_data_en,
  output logic half_full,
  output logic almost_edge
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DEPTH-1:0] store;
  logic [AW-1:0]    waddr, raddr;
  logic [PW-1:0]    wgray, rgray, wgray_rs, rgray_ws, wr_level;
  logic             push, rd_bit;

  serial_fifo_wr_side #(.DEPTH(DEPTH), .ALMOST(ALMOST)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .rgray_sync(rgray_ws),
    .wr_ready(wr_ready), .push(push), .waddr(waddr), .wgray(wgray),
    .level(wr_level), .half_full(half_full), .almost_edge(almost_edge)
  );

  serial_fifo_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_ws)
  );

  serial_fifo_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_rs)
  );

  always_ff @(posedge wr_clk)
    if (push) store[waddr] <= wr_data;

  serial_fifo_rd_side #(.DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .wgray_sync(wgray_rs),
    .mem_bit(store[raddr]), .raddr(raddr), .rgray(rgray),
    .out_bit(rd_bit), .rd_valid(rd_valid)
  );

  assign rd_data_en = rd_oe;
  assign rd_data    = rd_oe & rd_bit;
endmodule

// File: rtl/serial_fifo_chk.sv
module serial_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int PW   = $clog2(DEPTH) + 1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_ready,
  input logic [PW-1:0] wr_level,
  input logic          half_full,
  input logic          rd_en,
  input logic          rd_valid,
  input logic          out_bit
);
  AST_LEVEL_BOUND: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_level <= PW'(DEPTH)); // R3

  AST_NO_GROWTH_WHEN_REFUSED: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_ready |=> wr_level <= $past(wr_level)); // R1

  AST_HALF_RISE_BY_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $rose(half_full) |-> $past(wr_en && wr_ready)); // R5

  AST_HOLD_WHEN_STALLED: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_valid && !rd_en) |=> (rd_valid && $stable(out_bit))); // R2
endmodule

bind serial_fifo_dc serial_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en),
  .wr_ready(wr_ready), .wr_level(wr_level), .half_full(half_full),
  .rd_en(rd_en), .rd_valid(rd_valid), .out_bit(rd_bit)
);

// File: tb/serial_fifo_dc_tb.sv
module serial_fifo_dc_tb;
  localparam int DEPTH  = 64;
  localparam int ALMOST = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_data = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rd_oe = 1'b1;
  logic wr_ready, rd_valid, rd_data, rd_data_en, half_full, almost_edge;

  int n_tests = 0, n_fail = 0, n_written = 0;
  bit model[$];

  always #10 clk = ~clk;

  serial_fifo_dc #(.DEPTH(DEPTH), .ALMOST(ALMOST)) u_dut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_data(wr_data),
    .wr_en(wr_en), .wr_ready(wr_ready), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_oe(rd_oe), .rd_data(rd_data), .rd_data_en(rd_data_en),
    .half_full(half_full), .almost_edge(almost_edge)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pat(input int i);
    return 1'((i ^ (i >> 2) ^ (i >> 5)) & 1);
  endfunction

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic push_one(input bit b);
    wr_en = 1'b1;
    wr_data = b;
    if (wr_ready) model.push_back(b);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pop_one();
    bit exp;
    exp = model.size() > 0 ? model[0] : 1'b0;
    check(rd_valid == 1'b1, "R2 valid before pop", int'(rd_valid), 1);
    check(rd_data == exp, "R4 popped bit", int'(rd_data), int'(exp));
    rd_en = 1'b1;
    if (rd_valid && model.size() > 0) void'(model.pop_front());
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_flags(input int stored, input string tag);
    bit exp_hf, exp_ae, exp_rdy;
    exp_hf  = stored >= DEPTH / 2;
    exp_ae  = (stored <= ALMOST) || (stored >= DEPTH - ALMOST);
    exp_rdy = stored < DEPTH;
    check(half_full == exp_hf, {"R5 half_full ", tag}, int'(half_full), int'(exp_hf));
    check(almost_edge == exp_ae, {"R6 almost_edge ", tag}, int'(almost_edge), int'(exp_ae));
    check(wr_ready == exp_rdy, {"R3 wr_ready ", tag}, int'(wr_ready), int'(exp_rdy));
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R10: flags during and after reset
    #35;
    check(wr_ready == 1'b1, "R10 wr_ready in reset", int'(wr_ready), 1);
    check(rd_valid == 1'b0, "R10 rd_valid in reset", int'(rd_valid), 0);
    check(half_full == 1'b0, "R10 half_full in reset", int'(half_full), 0);
    check(almost_edge == 1'b1, "R10 almost_edge in reset", int'(almost_edge), 1);
    @(negedge clk);
    rst_n = 1'b1;
    cycles(2);
    check(wr_ready == 1'b1 && rd_valid == 1'b0, "R10 after release", int'({wr_ready, rd_valid}), 2);

    // R8: latency of first bit through three read-side stages
    push_one(1'b1);
    n_written = 1;
    cycles(1);
    cycles(1);
    check(rd_valid == 1'b0, "R8 rd_valid after E+2", int'(rd_valid), 0);
    cycles(1);
    check(rd_valid == 1'b1, "R8 rd_valid after E+3", int'(rd_valid), 1);
    check(rd_data == 1'b1 && rd_data_en == 1'b1, "R11 driven bit", int'(rd_data), 1);
    cycles(3);
    check_flags(0, "R7 output bit uncounted");

    // R5 R6 R3 R7: sweep every occupancy while the output bit stays parked
    for (int i = 1; i <= DEPTH; i++) begin
      push_one(pat(i));
      n_written++;
      cycles(5);
      check_flags(n_written - 1, $sformatf("level %0d", n_written - 1));
    end

    // R1: refused write leaves contents intact
    push_one(1'b1);
    cycles(3);
    check(model.size() == DEPTH + 1, "R1 model size", model.size(), DEPTH + 1);
    check(wr_ready == 1'b0, "R1 still full after refused write", int'(wr_ready), 0);

    // R2: stalled output holds
    cycles(4);
    check(rd_valid == 1'b1 && rd_data == model[0], "R2 hold while stalled", int'(rd_data), int'(model[0]));

    // R11: output enable low
    rd_oe = 1'b0;
    #1;
    check(rd_data_en == 1'b0 && rd_data == 1'b0, "R11 undriven", int'({rd_data_en, rd_data}), 0);
    rd_oe = 1'b1;
    #1;

    // R9: one read frees a slot two write edges later
    pop_one();
    check(wr_ready == 1'b0, "R9 wr_ready after P", int'(wr_ready), 0);
    cycles(1);
    check(wr_ready == 1'b0, "R9 wr_ready after P+1", int'(wr_ready), 0);
    cycles(1);
    check(wr_ready == 1'b1, "R9 wr_ready after P+2", int'(wr_ready), 1);

    // R4: drain everything in order
    while (model.size() > 0) begin
      if (rd_valid) pop_one();
      else cycles(1);
    end
    cycles(6);
    check(rd_valid == 1'b0, "R4 empty after drain", int'(rd_valid), 0);
    check_flags(0, "after drain");

    // R2: rd_en high with nothing presented consumes nothing
    rd_en = 1'b1;
    cycles(4);
    rd_en = 1'b0;
    push_one(1'b0);
    push_one(1'b1);
    cycles(6);
    check(rd_valid == 1'b1 && rd_data == 1'b0, "R2 first bit survives idle rd_en", int'(rd_data), 0);
    pop_one();
    cycles(3);
    pop_one();
    cycles(6);

    // R4 R1 R2: mixed stalls on both sides
    for (int c = 0; c < 1500; c++) begin
      bit we, re;
      we = (c % 7) != 3 && (c % 11) != 0;
      re = (c < 400) ? ((c % 3) == 0) : ((c % 5) != 1);
      if (re && rd_valid) begin
        check(rd_data == model[0], "R4 stream order", int'(rd_data), int'(model[0]));
        void'(model.pop_front());
      end
      if (we && wr_ready) model.push_back(pat(c + 100));
      rd_en = re;
      wr_en = we;
      wr_data = pat(c + 100);
      @(posedge clk);
      @(negedge clk);
    end
    wr_en = 1'b0;
    rd_en = 1'b0;
    cycles(6);
    while (model.size() > 0) begin
      if (rd_valid) pop_one();
      else cycles(1);
    end
    cycles(6);
    check(rd_valid == 1'b0, "R4 empty after stream", int'(rd_valid), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule